// File: doc/BRIEF.md
# Eight-Bit Arithmetic-Logic Unit with Output Shifter

This block is a purely combinational arithmetic-logic unit. Each cycle it takes two operands, a carry input and a five-bit operation code, and computes the result directly from those inputs. Two sections compute in parallel. The arithmetic section is a single adder. It takes operand A, an operand derived from B that the code picks, and the carry input. The logic section forms a bitwise function of A and B.

One bit of the operation code picks which section drives the unshifted result. Two further code bits then always pass that result through a one-position shifter stage, and the shifter output is the final value. A carry output and a zero flag go with the result. The block has no clock and no state. A surrounding datapath registers the result wherever it needs to.

Top module: `alu8_core`

## Requirements
- R1: With op_sel[2]=0 and op_sel[1:0]=00, the arithmetic result is A plus carry_in. With op_sel[1:0]=01 it is A+B+carry_in. Results wrap modulo 2^8.
- R2: With op_sel[2]=0 and op_sel[1:0]=10, the arithmetic result is A plus the ones' complement of B plus carry_in, which is A-B when carry_in=1. With op_sel[1:0]=11 it is A-1 when carry_in=0 and A unchanged when carry_in=1.
- R3: With op_sel[2]=1, op_sel[1:0] selects the logic result: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives NOT A. carry_in has no effect on this result.
- R4: op_sel[2] picks the unshifted result: the arithmetic result when it is 0, the logic result when it is 1.
- R5: op_sel[4:3]=01 shifts the unshifted result left by one and fills bit 0 with 0. op_sel[4:3]=10 shifts it right by one and fills bit 7 with 0.
- R6: op_sel[4:3]=00 passes the unshifted result to y_out unchanged. op_sel[4:3]=11 drives y_out to all zeros.
- R7: carry_out is the ninth bit of the adder sum while op_sel[2]=0, whatever the shift setting. When op_sel[2]=1 it is 0. For subtraction it is 1 when no borrow occurs. For the decrement code it is 1 unless A=0 and carry_in=0.
- R8: zero_out is 1 exactly when the final eight-bit y_out is zero, including when the shifter clears the result or shifts the last set bit out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| carry_in | input | 1 | Carry input to the adder |
| op_sel | input | 5 | Operation code: [1:0] function, [2] logic/arith, [4:3] shift |
| y_out | output | 8 | Final shifted result |
| carry_out | output | 1 | Adder carry, 0 for logic operations |
| zero_out | output | 1 | High when y_out is zero |

## Verification
The block holds no state, so a wrong internal decode shows at the ports within the same evaluation as the faulty input. There is no later cycle in which a fault could hide. An adder operand picked for the wrong code shows up as a wrong y_out, and often as a wrong carry_out as well. A shifter that fills with the wrong bit only shows when an edge bit of the operand is set. For that reason the bench sweeps all 64 combinations of code and carry with several random operands, and adds directed cases at the wrap points: A=0 decrement, A=FF increment and A equal to B subtraction. A fault in the logic/arithmetic mux shows as a carry that leaks into logic codes or a wrong y_out.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned SEL_W = 5;

  typedef enum logic [1:0] {
    FN_0 = 2'b00,
    FN_1 = 2'b01,
    FN_2 = 2'b10,
    FN_3 = 2'b11
  } fn_code_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_CLEAR = 2'b11
  } shift_code_e;

  // Second adder operand chosen by the function code.
  function automatic logic [7:0] addend8(input fn_code_e fn, input logic [7:0] b);
    case (fn)
      FN_0:    return 8'h00;
      FN_1:    return b;
      FN_2:    return ~b;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  fn_code_e         fn,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int unsigned SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] addend;
  logic [SUM_W-1:0] sum;

  always_comb begin
    case (fn)
      FN_0:    addend = '0;
      FN_1:    addend = b;
      FN_2:    addend = ~b;
      default: addend = '1;
    endcase
  end

  assign sum  = {1'b0, a} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
  assign res  = sum[WIDTH-1:0];
  assign cout = sum[WIDTH];

  always_comb begin
    if (fn == FN_0 && !cin)
      AST_PASS_A: assert (res == a && !cout); // R1
    if (fn == FN_3 && cin)
      AST_DEC_HOLD: assert (res == a && cout); // R2
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  fn_code_e         fn,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (fn)
      FN_0:    res = a & b;
      FN_1:    res = a | b;
      FN_2:    res = a ^ b;
      default: res = ~a;
    endcase
  end

  always_comb begin
    if (fn == FN_3)
      AST_NOT_COMPLEMENT: assert ((res & a) == '0 && (res | a) == '1); // R3
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] d,
  input  shift_code_e      mode,
  output logic [WIDTH-1:0] q
);
  always_comb begin
    case (mode)
      SH_PASS:  q = d;
      SH_LEFT:  q = {d[WIDTH-2:0], 1'b0};
      SH_RIGHT: q = {1'b0, d[WIDTH-1:1]};
      default:  q = '0;
    endcase
  end

  always_comb begin
    if (mode == SH_LEFT)
      AST_SHL_FILL: assert (q[0] == 1'b0); // R5
    if (mode == SH_RIGHT)
      AST_SHR_FILL: assert (q[WIDTH-1] == 1'b0); // R5
    if (mode == SH_CLEAR)
      AST_CLEAR_ALL: assert (q == '0); // R6
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [SEL_W-1:0] op_sel,
  output logic [WIDTH-1:0] y_out,
  output logic             carry_out,
  output logic             zero_out
);
  fn_code_e         fn;
  shift_code_e      sh;
  logic             use_logic;
  logic [WIDTH-1:0] arith_res;
  logic             arith_cout;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] unshifted;

  assign fn        = fn_code_e'(op_sel[1:0]);
  assign use_logic = op_sel[2];
  assign sh        = shift_code_e'(op_sel[4:3]);

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .a(a_in), .b(b_in), .cin(carry_in), .fn(fn),
    .res(arith_res), .cout(arith_cout)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a(a_in), .b(b_in), .fn(fn), .res(logic_res)
  );

  assign unshifted = use_logic ? logic_res : arith_res;

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .d(unshifted), .mode(sh), .q(y_out)
  );

  assign carry_out = arith_cout & ~use_logic;
  assign zero_out  = ~|y_out;

  always_comb begin
    if (use_logic)
      AST_LOGIC_NO_CARRY: assert (!carry_out); // R7
    if (!use_logic)
      AST_ARITH_CARRY_FWD: assert (carry_out == arith_cout); // R7
    if (sh == SH_PASS)
      AST_PASS_THROUGH: assert (y_out == unshifted); // R6
    if (sh == SH_CLEAR)
      AST_ZERO_ON_CLEAR: assert (zero_out); // R8
  end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a, b;
  logic       cin;
  logic [4:0] sel;
  logic [7:0] y;
  logic       co, z;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .a_in(a), .b_in(b), .carry_in(cin), .op_sel(sel),
    .y_out(y), .carry_out(co), .zero_out(z)
  );

  // {sel, cin, a, b, y, carry, zero}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {5'b00000, 1'b0, 8'h3C, 8'h55, 8'h3C, 1'b0, 1'b0},
    {5'b00000, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},
    {5'b00001, 1'b0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    {5'b00010, 1'b1, 8'h20, 8'h20, 8'h00, 1'b1, 1'b1},
    {5'b00011, 1'b0, 8'h00, 8'h77, 8'hFF, 1'b0, 1'b0},
    {5'b00110, 1'b0, 8'hF0, 8'hFF, 8'h0F, 1'b0, 1'b0},
    {5'b01001, 1'b1, 8'h41, 8'h01, 8'h86, 1'b0, 1'b0},
    {5'b10111, 1'b0, 8'hA5, 8'h00, 8'h2D, 1'b0, 1'b0},
    {5'b11001, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},
    {5'b01101, 1'b1, 8'h80, 8'h00, 8'h00, 1'b0, 1'b1}
  };

  // Reference: signed integer arithmetic, carry from range tests.
  function automatic logic [8:0] model(input logic [4:0] s, input logic c,
                                       input logic [7:0] x, input logic [7:0] w);
    int   r;
    logic k;
    logic [7:0] u;
    if (!s[2]) begin
      case (s[1:0])
        2'd0: begin r = int'(x) + int'(c);               k = (r > 255); end
        2'd1: begin r = int'(x) + int'(w) + int'(c);     k = (r > 255); end
        2'd2: begin r = int'(x) - int'(w) - 1 + int'(c); k = (r >= 0);  end
        default: begin r = int'(x) - 1 + int'(c);        k = (r >= 0);  end
      endcase
      u = 8'(r & 255);
    end else begin
      k = 1'b0;
      case (s[1:0])
        2'd0: u = x & w;
        2'd1: u = x | w;
        2'd2: u = x ^ w;
        default: u = 8'hFF - x;
      endcase
    end
    case (s[4:3])
      2'd0: ;
      2'd1: u = 8'((int'(u) * 2) % 256);
      2'd2: u = 8'(int'(u) / 2);
      default: u = 8'h00;
    endcase
    return {k, u};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s sel/cin/a/b=%b/%b/%h/%h got {z,c,y}=%h exp %h",
               tag, sel, cin, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] s, input logic c,
                       input logic [7:0] x, input logic [7:0] w);
    @(posedge clk);
    sel = s; cin = c; a = x; b = w;
    @(negedge clk);
  endtask

  initial begin
    sel = '0; cin = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Directed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
      check("R1 R2 R3 R5 R6 R7 R8 table", {z, co, y},
            {VEC[i][0], VEC[i][1], VEC[i][9:2]});
    end

    // Full sweep of code and carry with random operands
    for (int s = 0; s < 32; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 4; k++) begin
          logic [8:0] e;
          logic [7:0] x, w;
          x = 8'($urandom);
          w = 8'($urandom);
          apply(5'(s), c[0], x, w);
          e = model(5'(s), c[0], x, w);
          check("R4 sweep", {z, co, y}, {(e[7:0] == 8'h00), e});
        end
      end
    end

    // Corner: decrement of zero, carry in clear
    apply(5'b00011, 1'b0, 8'h00, 8'h00);
    check("R2 dec zero", {z, co, y}, {1'b0, 1'b0, 8'hFF});
    // Corner: subtraction A<B borrows
    apply(5'b00010, 1'b1, 8'h10, 8'h11);
    check("R7 borrow", {z, co, y}, {1'b0, 1'b0, 8'hFF});
    // Corner: carry_in ignored by logic
    apply(5'b00100, 1'b1, 8'hF3, 8'h3F);
    check("R3 cin ignored", {z, co, y}, {1'b0, 1'b0, 8'h33});
    // Corner: shift-right drops only set bit
    apply(5'b10000, 1'b1, 8'h00, 8'h00);
    check("R8 shr to zero", {z, co, y}, {1'b0, 1'b0, 8'h00} | 10'h200);
    // Corner: carry kept while clearing
    apply(5'b11000, 1'b1, 8'hFF, 8'h00);
    check("R6 R7 clear keeps carry", {z, co, y}, {1'b1, 1'b1, 8'h00});

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule